// File: doc/BRIEF.md
# Double-Base Programmable Constant Multiplier

This block is the per-tap multiplier of a programmable transposed-form filter. It takes a signed input sample through a set of precomputed odd multiples: x, 3x, 9x, 27x and 5x. These are formed once by a shared generator and fed to every tap. From them it builds the product of x and an unsigned 8-bit coefficient magnitude.

The coefficient is never presented as a number. It arrives as a control word that describes the coefficient as a sum of up to three double-base terms. Each term is one of the odd multiples shifted left by a programmable amount. An extra common left shift carries the power-of-two factor of an even coefficient, so an even value reuses the lane settings of its odd part.

Three identical lanes each pick one multiple, or zero, and shift it. A two-adder tree sums the three terms. The sum is shifted by the common amount and registered. The sign of the coefficient is handled outside, by the structural adder that consumes the product. The control words are produced by an external lookup.

Top module: `dbase_mult`

## Requirements
- R1: While `rst` is high at a rising edge, `product` is 0 after that edge, including when it held a nonzero value before.
- R2: The lane select code is bits [2:0] of each lane field. The codes are 0 = zero, 1 = x, 2 = 3x, 3 = 9x, 4 = 27x and 5 = 5x. Codes 6 and 7 also give zero.
- R3: A lane shifts its selected multiple left by its shift field, bits [5:3] of the lane field, over the range 0 to 7.
- R4: `product` equals the sum of the three lane terms, shifted left by the common shift. It appears one clock after `ctrl` and the multiples are presented.
- R5: Lane k occupies `ctrl[6k+5:6k]`. The common shift is `ctrl[20:18]`. Any lane may carry any term. For example, 147 = (9x shifted by 4) + 3x gives the same product in whichever two lanes it is placed.
- R6: For every coefficient c from 1 to 255, encoded with at most three terms, `product` equals x*c exactly for every signed 8-bit x, including -128 and 127.
- R7: A lane shift and the common shift add together. The same coefficient gives the same product whether its power-of-two factor sits in the lane shifts, in the common shift, or is split between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mult_x1 | input | 13 | Shared multiple x (signed) |
| mult_x3 | input | 13 | Shared multiple 3x (signed) |
| mult_x9 | input | 13 | Shared multiple 9x (signed) |
| mult_x27 | input | 13 | Shared multiple 27x (signed) |
| mult_x5 | input | 13 | Shared multiple 5x (signed) |
| ctrl | input | 21 | Three lane fields (select and shift) and the common shift |
| product | output | 16 | Registered signed product x*c |

## Verification
The lane shift and the common shift can both act on the same term in the same cycle.

The bench provokes this by encoding one coefficient in several ways: with its power-of-two factor entirely in a lane shift, entirely in the common shift, or split between the two. It also runs every even coefficient through the odd-part-plus-common-shift form.

Each of these is judged against x*c computed arithmetically. A second overlap checked is a reset arriving in the same cycle that a nonzero product would load; the product must read zero.

// File: rtl/dbase_mult_pkg.sv
package dbase_mult_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned SH_W    = 3;
    localparam int unsigned N_LANES = 3;
    localparam int unsigned LANE_W  = SEL_W + SH_W;

    localparam logic [SEL_W-1:0] SEL_ZERO = 3'd0;
    localparam logic [SEL_W-1:0] SEL_X1   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_X3   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_X9   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_X27  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_X5   = 3'd5;

    typedef struct packed {
        logic [SH_W-1:0]  shift;
        logic [SEL_W-1:0] sel;
    } lane_ctrl_t;

    function automatic logic sel_is_idle(input logic [SEL_W-1:0] s);
        return (s == SEL_ZERO) || (s > SEL_X5);
    endfunction

endpackage

// File: rtl/dbase_term_lane.sv
module dbase_term_lane
    import dbase_mult_pkg::*;
#(
    parameter int unsigned M_W = 13,
    parameter int unsigned T_W = M_W + 7
) (
    input  logic signed [M_W-1:0] m1,
    input  logic signed [M_W-1:0] m3,
    input  logic signed [M_W-1:0] m9,
    input  logic signed [M_W-1:0] m27,
    input  logic signed [M_W-1:0] m5,
    input  lane_ctrl_t            cfg,
    output logic signed [T_W-1:0] term
);

    logic signed [M_W-1:0] picked;

    always_comb begin
        unique case (cfg.sel)
            SEL_X1:  picked = m1;
            SEL_X3:  picked = m3;
            SEL_X9:  picked = m9;
            SEL_X27: picked = m27;
            SEL_X5:  picked = m5;
            default: picked = '0;
        endcase
    end

    assign term = T_W'(picked) <<< cfg.shift;

endmodule

// File: rtl/dbase_sum_tree.sv
module dbase_sum_tree #(
    parameter int unsigned T_W = 20,
    parameter int unsigned S_W = T_W + 2
) (
    input  logic signed [T_W-1:0] t0,
    input  logic signed [T_W-1:0] t1,
    input  logic signed [T_W-1:0] t2,
    output logic signed [S_W-1:0] sum
);

    logic signed [S_W-1:0] first_pair;

    assign first_pair = S_W'(t0) + S_W'(t1);
    assign sum        = first_pair + S_W'(t2);

endmodule

// File: rtl/dbase_mult.sv
module dbase_mult
    import dbase_mult_pkg::*;
#(
    parameter int unsigned X_W    = 8,
    parameter int unsigned C_W    = 8,
    localparam int unsigned M_W   = X_W + 5,
    localparam int unsigned T_W   = M_W + (1 << SH_W) - 1,
    localparam int unsigned S_W   = T_W + 2,
    localparam int unsigned P_W   = X_W + C_W,
    localparam int unsigned CTRL_W = N_LANES * LANE_W + SH_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [M_W-1:0]    mult_x1,
    input  logic signed [M_W-1:0]    mult_x3,
    input  logic signed [M_W-1:0]    mult_x9,
    input  logic signed [M_W-1:0]    mult_x27,
    input  logic signed [M_W-1:0]    mult_x5,
    input  logic [CTRL_W-1:0]        ctrl,
    output logic signed [P_W-1:0]    product
);

    lane_ctrl_t            lane_cfg [N_LANES];
    logic signed [T_W-1:0] lane_term [N_LANES];
    logic [SH_W-1:0]       common_shift;
    logic signed [S_W-1:0] term_sum;
    logic signed [P_W-1:0] product_next;

    assign common_shift = ctrl[CTRL_W-1 -: SH_W];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_cfg[g] = lane_ctrl_t'(ctrl[g*LANE_W +: LANE_W]);

        dbase_term_lane #(.M_W(M_W), .T_W(T_W)) u_lane (
            .m1   (mult_x1),
            .m3   (mult_x3),
            .m9   (mult_x9),
            .m27  (mult_x27),
            .m5   (mult_x5),
            .cfg  (lane_cfg[g]),
            .term (lane_term[g])
        );
    end

    dbase_sum_tree #(.T_W(T_W), .S_W(S_W)) u_tree (
        .t0  (lane_term[0]),
        .t1  (lane_term[1]),
        .t2  (lane_term[2]),
        .sum (term_sum)
    );

    assign product_next = P_W'(term_sum) <<< common_shift;

    always_ff @(posedge clk) begin
        if (rst) product <= '0;
        else     product <= product_next;
    end

    // R1: reset clears the registered product
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (product == '0));

    // R2: all lanes idle (code 0, 6 or 7) gives a zero product
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_is_idle(lane_cfg[0].sel) && sel_is_idle(lane_cfg[1].sel) &&
         sel_is_idle(lane_cfg[2].sel)) |=> (product == '0));

    // R3: a lone x term in lane 0 appears shifted by the lane shift
    a_r3_lane_shift: assert property (@(posedge clk) disable iff (rst)
        (lane_cfg[0].sel == SEL_X1 && sel_is_idle(lane_cfg[1].sel) &&
         sel_is_idle(lane_cfg[2].sel) && common_shift == '0)
        |=> (product == (P_W'($past(mult_x1)) <<< $past(lane_cfg[0].shift))));

    // R7: a lone unshifted x term appears shifted by the common shift
    a_r7_common_shift: assert property (@(posedge clk) disable iff (rst)
        (lane_cfg[0].sel == SEL_X1 && lane_cfg[0].shift == '0 &&
         sel_is_idle(lane_cfg[1].sel) && sel_is_idle(lane_cfg[2].sel))
        |=> (product == (P_W'($past(mult_x1)) <<< $past(common_shift))));

endmodule

// File: tb/dbase_mult_tb_top.sv
`timescale 1ns/1ps
module dbase_mult_tb_top;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [12:0] m1, m3, m9, m27, m5;
    logic [20:0]        ctrl;
    logic signed [15:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [20:0] tab [256];

    always #4 clk = ~clk;

    dbase_mult dut_i (
        .clk(clk), .rst(rst),
        .mult_x1(m1), .mult_x3(m3), .mult_x9(m9), .mult_x27(m27), .mult_x5(m5),
        .ctrl(ctrl), .product(product)
    );

    function automatic int tv(input int s);
        case (s)
            1: return 1;
            2: return 3;
            3: return 9;
            4: return 27;
            5: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [5:0] lf(input int sel, input int sh);
        return {3'(sh), 3'(sel)};
    endfunction

    // Search an encoding: odd part over three lanes, power-of-two factor in common shift
    function automatic logic [20:0] encode(input int c);
        int o;
        int tz;
        o = c;
        tz = 0;
        while (o > 0 && (o % 2) == 0) begin
            o = o / 2;
            tz++;
        end
        for (int s1 = 1; s1 <= 5; s1++)
            for (int h1 = 0; h1 < 8; h1++)
                for (int s2 = 0; s2 <= 5; s2++)
                    for (int h2 = 0; h2 < 8; h2++)
                        for (int s3 = 0; s3 <= 5; s3++)
                            for (int h3 = 0; h3 < 8; h3++)
                                if ((tv(s1) << h1) + (tv(s2) << h2) + (tv(s3) << h3) == o)
                                    return {3'(tz), lf(s3, h3), lf(s2, h2), lf(s1, h1)};
        return '0;
    endfunction

    task automatic set_x(input int x);
        m1  = 13'(x);
        m3  = 13'(x * 3);
        m9  = 13'(x * 9);
        m27 = 13'(x * 27);
        m5  = 13'(x * 5);
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive at a falling edge, sample one falling edge later (one register)
    task automatic apply(input string req, input int x, input logic [20:0] cw, input int exp);
        @(negedge clk);
        set_x(x);
        ctrl = cw;
        @(negedge clk);
        check(req, int'(product), exp);
    endtask

    initial begin : wd
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int xs [8];
        xs = '{-128, -77, -1, 0, 1, 5, 93, 127};
        set_x(99);
        ctrl = {3'd0, lf(0, 0), lf(0, 0), lf(1, 2)};
        for (int c = 0; c < 256; c++) tab[c] = encode(c);
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(product), 0);
        rst = 1'b0;

        // R2: each code in lane 0 with shift 2
        for (int s = 0; s < 8; s++)
            apply("R2 select code", 55, {3'd0, lf(0, 0), lf(0, 0), lf(s, 2)}, 55 * tv(s) * 4);
        // R2: codes 6 and 7 in every lane give zero
        apply("R2 unused codes", -100, {3'd5, lf(7, 1), lf(6, 7), lf(7, 3)}, 0);

        // R3: full shift range per lane
        for (int h = 0; h < 8; h++) begin
            apply("R3 lane0 shift", -128, {3'd0, lf(0, 0), lf(0, 0), lf(1, h)}, -128 * (1 << h));
            apply("R3 lane2 shift", 127,  {3'd0, lf(1, h), lf(0, 0), lf(0, 0)}, 127 * (1 << h));
        end

        // R4: three-term sum with common shift: (27<<1 + 5<<3 + 9) << 1 = 206
        apply("R4 three terms", -77, {3'd1, lf(3, 0), lf(5, 3), lf(4, 1)}, -77 * 206);

        // R5: 147 = (9x<<4) + 3x in different lane pairs
        apply("R5 lanes 0,1", 93,  {3'd0, lf(0, 0), lf(2, 0), lf(3, 4)}, 93 * 147);
        apply("R5 lanes 2,0", 93,  {3'd0, lf(3, 4), lf(0, 0), lf(2, 0)}, 93 * 147);
        apply("R5 lanes 1,2", -128, {3'd0, lf(2, 0), lf(3, 4), lf(0, 0)}, -128 * 147);

        // R7: 128 and 96 with the factor in lane shift, common shift, or split
        apply("R7 128 lane",   -77, {3'd0, lf(0, 0), lf(0, 0), lf(1, 7)}, -77 * 128);
        apply("R7 128 common", -77, {3'd7, lf(0, 0), lf(0, 0), lf(1, 0)}, -77 * 128);
        apply("R7 128 split",  -77, {3'd3, lf(0, 0), lf(0, 0), lf(1, 4)}, -77 * 128);
        apply("R7 96 lane",    127, {3'd0, lf(0, 0), lf(0, 0), lf(2, 5)}, 127 * 96);
        apply("R7 96 split",   127, {3'd3, lf(0, 0), lf(0, 0), lf(2, 2)}, 127 * 96);

        // R6: every nonzero coefficient, several signed inputs
        for (int c = 1; c < 256; c++) begin
            if (tab[c] == '0) check("R6 encoding found", 0, c);
            for (int k = 0; k < 8; k++)
                apply("R6 sweep", xs[k], tab[c], xs[k] * c);
        end

        // R1: reset in the cycle a nonzero product would load
        @(negedge clk);
        set_x(127);
        ctrl = tab[255];
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset over load", int'(product), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'(product), 127 * 255);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule